// File: doc/BRIEF.md
# Boot Shadow Sequencer

This block owns the processor's reset line. Whenever a reset cause appears (chip power-on, a reset command from the spacecraft, or the watchdog), it pulls the CPU into reset. It then copies a fixed-length boot image out of a read-only memory into CPU RAM, one word per cycle. The CPU is let go only after the final word has landed in RAM. A restart request that arrives in the middle of a copy throws away the partial copy and starts again at the first word. The most recent cause stays visible on a two-bit cause output until the next one arrives.

The read-only memory has a one-cycle read latency. Each RAM write therefore carries the word that was requested on the previous cycle. After the CPU is running, the block also paces its memory cycles: every access gets exactly one wait state before it is acknowledged.

Top module: `boot_shadow_seq`

## Requirements
- R1: While `rst` is high, `cpu_rst` and `copy_busy` are 1, `copy_done` is 0, `cpu_mem_ack` is 0, and `rst_cause` reads 1 (power-on).
- R2: Each copy writes ROM word i to RAM address `RAM_BASE + i` for i = 0 to `COPY_LEN-1`. Words go out in ascending order, one per cycle, exactly once each, with no write outside that range.
- R3: A RAM write always carries the ROM data returned for the read issued on the cycle before it.
- R4: `cpu_rst` is high for the whole copy. It falls on the `COPY_LEN+2`-th clock edge after the last edge that sampled a reset cause, and `copy_busy` implies `cpu_rst`.
- R5: `copy_done` rises exactly one cycle before `cpu_rst` falls. It stays 1, with `copy_busy` at 0, for as long as `cpu_rst` is low.
- R6: A one-cycle pulse on `cmd_rst_req` or `wdog_rst_req` while the CPU runs puts it back in reset and recopies the whole image. `rst_cause` becomes 2 for a command and 3 for the watchdog.
- R7: A reset cause that arrives during a copy restarts the copy from ROM address 0. Release timing is counted from that later cause.
- R8: When several causes are sampled on the same edge, the recorded cause follows the priority power-on (1), then watchdog (3), then command (2).
- R9: Once the CPU runs, a memory request that starts while no acknowledge is due is acknowledged on the following cycle, never on the same cycle. A request held high is acknowledged on every second cycle.
- R10: `cpu_mem_ack` is never 1 while `cpu_rst` is 1. Memory requests made during reset or during a copy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cmd_rst_req | input | 1 | Spacecraft reset command request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | ROM_AW | ROM read address |
| rom_rdata | input | DATA_W | ROM read data, valid one cycle after `rom_en` |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | RAM_AW | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| cpu_mem_req | input | 1 | CPU memory cycle request |
| cpu_mem_ack | output | 1 | CPU memory cycle acknowledge, after one wait state |
| cpu_rst | output | 1 | CPU reset, active high |
| copy_busy | output | 1 | Boot image copy in progress |
| copy_done | output | 1 | Copy finished |
| rst_cause | output | 2 | Last reset cause: 1 power-on, 2 command, 3 watchdog |

## Verification
The copy is driven by each cause on its own, by a watchdog cause that interrupts a command-started copy, and the reverse. It is also driven by two command pulses one cycle apart and by simultaneous causes. These cases separate a sequencer that restarts from zero from one that resumes, and they show whether the cause register honours priority. Every RAM write is matched against a bench model of the ROM, so a one-cycle skew between address and data shows up as a data mismatch. The wait-state logic is tried with a single request pulse and with a held request, which separates a zero-wait or a two-wait design from the required one-wait pattern.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        ST_COPY    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_POWER = 2'd1,
        CAUSE_CMD   = 2'd2,
        CAUSE_WDOG  = 2'd3
    } rst_cause_e;

    typedef struct packed {
        logic       valid;
        rst_cause_e cause;
    } rst_event_t;

    // Priority: power-on, then watchdog, then command.
    function automatic rst_event_t pick_cause(input logic por, input logic cmd, input logic wdog);
        rst_event_t ev;
        ev.valid = por | cmd | wdog;
        if (por)       ev.cause = CAUSE_POWER;
        else if (wdog) ev.cause = CAUSE_WDOG;
        else if (cmd)  ev.cause = CAUSE_CMD;
        else           ev.cause = CAUSE_NONE;
        return ev;
    endfunction

endpackage

// File: rtl/boot_rst_arbiter.sv
module boot_rst_arbiter
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_req,
    input  logic       wdog_req,
    output logic       restart,
    output rst_cause_e cause
);

    rst_event_t ev;
    rst_cause_e cause_q;

    always_comb begin
        ev = pick_cause(rst, cmd_req, wdog_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_POWER;
        end else if (ev.valid) begin
            cause_q <= ev.cause;
        end
    end

    assign restart = ev.valid;
    assign cause   = cause_q;

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
    import boot_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ROM_AW   = 8,
    parameter int RAM_AW   = 12,
    parameter int COPY_LEN = 16,
    parameter int RAM_BASE = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output seq_state_e        state
);

    localparam int IDX_W = $clog2(COPY_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COPY_LEN - 1);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(COPY_LEN);

    seq_state_e       state_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic             rd_valid_q;
    logic             issue;
    logic             last_write;

    // A read is issued while in the copy state and words remain.
    assign issue      = (state_q == ST_COPY) && (rd_idx_q < END_IDX) && !restart;
    assign last_write = rd_valid_q && (wr_idx_q == LAST_IDX) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q    <= ST_COPY;
            rd_idx_q   <= '0;
            wr_idx_q   <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= issue;
            if (issue) begin
                rd_idx_q <= rd_idx_q + IDX_W'(1);
                wr_idx_q <= rd_idx_q;
            end
            case (state_q)
                ST_COPY:    if (last_write) state_q <= ST_RELEASE;
                ST_RELEASE: state_q <= ST_RUN;
                default:    state_q <= ST_RUN;
            endcase
        end
    end

    assign rom_en    = issue;
    assign rom_addr  = ROM_AW'(rd_idx_q);
    assign ram_we    = rd_valid_q && !restart;
    assign ram_waddr = RAM_AW'(RAM_BASE) + RAM_AW'(wr_idx_q);
    assign ram_wdata = rom_rdata;
    assign state     = state_q;

endmodule

// File: rtl/boot_wait_gen.sv
module boot_wait_gen (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic req,
    output logic ack
);

    logic pending_q;

    // One wait state: an accepted request is acknowledged next cycle.
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= !pending_q && req;
        end
    end

    assign ack = pending_q && !hold;

endmodule

// File: rtl/boot_shadow_seq.sv
module boot_shadow_seq
    import boot_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ROM_AW   = 8,
    parameter int RAM_AW   = 12,
    parameter int COPY_LEN = 16,
    parameter int RAM_BASE = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_rst_req,
    input  logic              wdog_rst_req,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic              cpu_mem_req,
    output logic              cpu_mem_ack,
    output logic              cpu_rst,
    output logic              copy_busy,
    output logic              copy_done,
    output logic [1:0]        rst_cause
);

    logic       restart;
    rst_cause_e cause;
    seq_state_e state;

    boot_rst_arbiter i_arb (
        .clk      (clk),
        .rst      (rst),
        .cmd_req  (cmd_rst_req),
        .wdog_req (wdog_rst_req),
        .restart  (restart),
        .cause    (cause)
    );

    boot_copy_engine #(
        .DATA_W   (DATA_W),
        .ROM_AW   (ROM_AW),
        .RAM_AW   (RAM_AW),
        .COPY_LEN (COPY_LEN),
        .RAM_BASE (RAM_BASE)
    ) i_copy (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .rom_rdata (rom_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .state     (state)
    );

    assign cpu_rst   = (state != ST_RUN);
    assign copy_busy = (state == ST_COPY);
    assign copy_done = (state != ST_COPY);
    assign rst_cause = cause;

    boot_wait_gen i_wait (
        .clk  (clk),
        .rst  (rst),
        .hold (cpu_rst),
        .req  (cpu_mem_req),
        .ack  (cpu_mem_ack)
    );

endmodule

// File: rtl/boot_shadow_seq_chk.sv
module boot_shadow_seq_chk #(
    parameter int RAM_AW   = 12,
    parameter int COPY_LEN = 16,
    parameter int RAM_BASE = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_rst_req,
    input logic              wdog_rst_req,
    input logic              rom_en,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_waddr,
    input logic              cpu_mem_req,
    input logic              cpu_mem_ack,
    input logic              cpu_rst,
    input logic              copy_busy,
    input logic              copy_done,
    input logic [1:0]        rst_cause
);

    localparam logic [RAM_AW-1:0] LO = RAM_AW'(RAM_BASE);
    localparam logic [RAM_AW-1:0] HI = RAM_AW'(RAM_BASE + COPY_LEN);

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_waddr >= LO) && (ram_waddr < HI)); // R2
    AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(rom_en)); // R3
    AST_BUSY_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
        copy_busy |-> cpu_rst); // R4
    AST_DONE_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> $past(copy_done)); // R5
    AST_RUN_IS_DONE: assert property (@(posedge clk) disable iff (rst)
        !cpu_rst |-> copy_done && !copy_busy); // R5
    AST_CMD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        cmd_rst_req |=> copy_busy && cpu_rst); // R6
    AST_WDOG_WINS: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |=> rst_cause == 2'd3); // R8
    AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        cpu_mem_ack |-> $past(cpu_mem_req)); // R9
    AST_NO_BACK_TO_BACK_ACK: assert property (@(posedge clk) disable iff (rst)
        cpu_mem_ack |=> !cpu_mem_ack); // R9
    AST_NO_ACK_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        cpu_mem_ack |-> !cpu_rst); // R10

endmodule

bind boot_shadow_seq boot_shadow_seq_chk #(
    .RAM_AW   (RAM_AW),
    .COPY_LEN (COPY_LEN),
    .RAM_BASE (RAM_BASE)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_rst_req  (cmd_rst_req),
    .wdog_rst_req (wdog_rst_req),
    .rom_en       (rom_en),
    .ram_we       (ram_we),
    .ram_waddr    (ram_waddr),
    .cpu_mem_req  (cpu_mem_req),
    .cpu_mem_ack  (cpu_mem_ack),
    .cpu_rst      (cpu_rst),
    .copy_busy    (copy_busy),
    .copy_done    (copy_done),
    .rst_cause    (rst_cause)
);

// File: tb/test_boot_shadow_seq.sv
module test_boot_shadow_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int ROM_AW     = 8;
    localparam int RAM_AW     = 12;
    localparam int COPY_LEN   = 16;
    localparam int RAM_BASE   = 256;
    localparam int NVEC       = 6;

    // {first cause, second cause, gap, expected rst_cause}; cause 1=cmd 2=wdog 3=both
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd1, 2'd0, 8'd0,  2'd2},
        {2'd2, 2'd0, 8'd0,  2'd3},
        {2'd1, 2'd2, 8'd5,  2'd3},
        {2'd2, 2'd1, 8'd10, 2'd2},
        {2'd1, 2'd1, 8'd1,  2'd2},
        {2'd3, 2'd0, 8'd0,  2'd3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_rst_req = 1'b0;
    logic              wdog_rst_req = 1'b0;
    logic              rom_en;
    logic [ROM_AW-1:0] rom_addr;
    logic [DATA_W-1:0] rom_rdata = '0;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic              cpu_mem_req = 1'b0;
    logic              cpu_mem_ack;
    logic              cpu_rst;
    logic              copy_busy;
    logic              copy_done;
    logic [1:0]        rst_cause;

    int errors = 0;
    int checks = 0;
    int exp_idx = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_shadow_seq #(
        .DATA_W   (DATA_W),
        .ROM_AW   (ROM_AW),
        .RAM_AW   (RAM_AW),
        .COPY_LEN (COPY_LEN),
        .RAM_BASE (RAM_BASE)
    ) i_boot_shadow_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_rst_req  (cmd_rst_req),
        .wdog_rst_req (wdog_rst_req),
        .rom_en       (rom_en),
        .rom_addr     (rom_addr),
        .rom_rdata    (rom_rdata),
        .ram_we       (ram_we),
        .ram_waddr    (ram_waddr),
        .ram_wdata    (ram_wdata),
        .cpu_mem_req  (cpu_mem_req),
        .cpu_mem_ack  (cpu_mem_ack),
        .cpu_rst      (cpu_rst),
        .copy_busy    (copy_busy),
        .copy_done    (copy_done),
        .rst_cause    (rst_cause)
    );

    function automatic logic [DATA_W-1:0] rom_word(input int a);
        return DATA_W'(a * 263) ^ 16'hC3A5;
    endfunction

    // ROM model with one cycle of read latency
    always @(posedge clk) begin
        if (rom_en) rom_rdata <= rom_word(int'(rom_addr));
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // RAM write monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst || cmd_rst_req || wdog_rst_req) begin
            exp_idx = 0;
        end else if (ram_we) begin
            check(exp_idx < COPY_LEN, "R2", "write beyond image", exp_idx, COPY_LEN - 1);
            check(int'(ram_waddr) == RAM_BASE + exp_idx, "R2", "write address",
                  int'(ram_waddr), RAM_BASE + exp_idx);
            check(ram_wdata == rom_word(exp_idx), "R3", "write data",
                  int'(ram_wdata), int'(rom_word(exp_idx)));
            exp_idx++;
        end
    end

    task automatic drive_src(input logic [1:0] src);
        cmd_rst_req  = src[0];
        wdog_rst_req = src[1];
    endtask

    task automatic pulse(input logic [1:0] src);
        @(posedge clk); #1;
        drive_src(src);
        @(posedge clk); #1;
        drive_src(2'd0);
    endtask

    // Counts cycles of held reset after the last sampled cause
    task automatic measure(input int exp_cause, input string req);
        int n = 0;
        int done_hi = 0;
        int ack_bad = 0;
        logic last_done = 1'b0;
        @(negedge clk);
        while (cpu_rst && n < 1000) begin
            n++;
            if (copy_done) done_hi++;
            if (cpu_mem_ack) ack_bad++;
            last_done = copy_done;
            @(negedge clk);
        end
        check(n == COPY_LEN + 2, "R4", "cycles in reset", n, COPY_LEN + 2);
        check(done_hi == 1 && last_done, "R5", "done cycles before release", done_hi, 1);
        check(copy_done && !copy_busy, "R5", "done after release", int'(copy_done), 1);
        check(exp_idx == COPY_LEN, "R2", "words written", exp_idx, COPY_LEN);
        check(int'(rst_cause) == exp_cause, req, "rst_cause", int'(rst_cause), exp_cause);
        check(ack_bad == 0, "R10", "acks while in reset", ack_bad, 0);
    endtask

    initial begin
        repeat (300 * COPY_LEN) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cpu_mem_req = 1'b1;
        repeat (2) @(negedge clk);
        // R1: power-on reset state
        check(cpu_rst == 1'b1, "R1", "cpu_rst in reset", int'(cpu_rst), 1);
        check(copy_busy == 1'b1, "R1", "busy in reset", int'(copy_busy), 1);
        check(copy_done == 1'b0, "R1", "done in reset", int'(copy_done), 0);
        check(rst_cause == 2'd1, "R1", "cause in reset", int'(rst_cause), 1);
        check(cpu_mem_ack == 1'b0, "R10", "ack in reset", int'(cpu_mem_ack), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        measure(1, "R1");
        @(posedge clk); #1;
        cpu_mem_req = 1'b0;
        repeat (3) @(posedge clk);

        // Table walk: R6, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            pulse(VEC[v][13:12]);
            if (VEC[v][11:10] != 2'd0) begin
                repeat (int'(VEC[v][9:2])) @(posedge clk);
                pulse(VEC[v][11:10]);
            end
            measure(int'(VEC[v][1:0]), (VEC[v][11:10] != 2'd0) ? "R7" :
                                       (VEC[v][13:12] == 2'd3) ? "R8" : "R6");
            repeat (2) @(posedge clk);
        end

        // R8: power-on wins over both other causes
        @(posedge clk); #1;
        rst = 1'b1;
        drive_src(2'd3);
        @(posedge clk); #1;
        rst = 1'b0;
        drive_src(2'd0);
        measure(1, "R8");

        // R9: single request pulse gets one wait state
        @(posedge clk); #1;
        cpu_mem_req = 1'b1;
        @(negedge clk);
        check(cpu_mem_ack == 1'b0, "R9", "ack in request cycle", int'(cpu_mem_ack), 0);
        @(posedge clk); #1;
        cpu_mem_req = 1'b0;
        @(negedge clk);
        check(cpu_mem_ack == 1'b1, "R9", "ack after one wait", int'(cpu_mem_ack), 1);
        @(negedge clk);
        check(cpu_mem_ack == 1'b0, "R9", "ack drops", int'(cpu_mem_ack), 0);

        // R9: held request acknowledged every second cycle
        repeat (2) @(posedge clk);
        #1;
        cpu_mem_req = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(cpu_mem_ack == logic'(c % 2), "R9", "held request ack pattern",
                  int'(cpu_mem_ack), c % 2);
        end
        @(posedge clk); #1;
        cpu_mem_req = 1'b0;
        repeat (3) @(posedge clk);

        // R10: request held across a watchdog restart never acknowledged in reset
        #1;
        cpu_mem_req = 1'b1;
        pulse(2'd2);
        measure(3, "R10");
        @(posedge clk); #1;
        cpu_mem_req = 1'b0;
        repeat (2) @(posedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule